// File: doc/BRIEF.md
# Configurable Ready/Busy Status Pin Controller

This block drives an open-drain style status pin for a flash-memory write engine. It watches when the engine is busy, when it finishes, and whether an erase or program operation is suspended. From these inputs it produces a pin drive value and an output enable. When the enable is high the pin is pulled low. When the enable is low the pin is high-impedance, and an external pull-up defines its level.

The block has four behaviours, selected by a 2-bit configuration write:

- **Level mode.** After reset the pin acts as a level ready/busy line. It is pulled low while the engine is busy and released when the engine is idle or suspended.
- **Pulse modes.** The other three codes turn the pin into a short low-going interrupt pulse. Code 01 pulses on erase completion, code 10 on program completion, and code 11 on either. Each pulse lasts a fixed, parameterised number of clocks.

A low level on the power-down pin releases the pin and restores level mode.

Top module: `sts_pin_ctrl`

## Requirements
- R1: After synchronous reset the block is in level mode with `sts_oe` = 0 and `sts_out` = 1.
- R2: In level mode, when `wsm_busy` = 1, both suspend flags = 0 and `pdn_n` = 1 in a cycle, `sts_oe` is 1 in the following cycle.
- R3: In level mode, `sts_oe` is 0 in the cycle after one where `wsm_busy` = 0 or either suspend flag is 1. Completion events have no effect in this mode.
- R4: In the pulse modes (codes 01, 10, 11), `wsm_busy` never drives the pin. `sts_oe` is 0 except during pulses.
- R5: Qualifying completions depend on the code: code 01 accepts only `erase_done`, code 10 accepts only `prog_done`, and code 11 accepts either. After a qualifying completion, `sts_oe` is 1 for exactly `PULSE_LEN` cycles, starting in the cycle after the event.
- R6: A qualifying completion during an active pulse restarts the count from `PULSE_LEN`. Pulses do not stack, so the pin stays low without a gap.
- R7: A configuration write (`cfg_wr` = 1, code on `cfg_code`, code 00 = level) is ignored while `wsm_busy` = 1. An accepted write takes effect in the next cycle and cancels any running pulse.
- R8: While `pdn_n` = 0, `sts_oe` is 0 in the following cycle, the mode returns to level, and any running pulse is cancelled.
- R9: `sts_out` is always the complement of `sts_oe`: the drive value is 0 when enabled and 1 when released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Deep power-down / reset pin, active low |
| wsm_busy | input | 1 | Write engine is running an operation |
| erase_done | input | 1 | One-cycle erase completion event |
| prog_done | input | 1 | One-cycle program completion event |
| erase_susp | input | 1 | Erase is suspended |
| prog_susp | input | 1 | Program is suspended |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_code | input | 2 | Mode code: 00 level, 01 erase, 10 program, 11 both |
| sts_out | output | 1 | Pin drive value |
| sts_oe | output | 1 | Pin output enable (1 pulls the pin low) |

## Verification
A wrong stored mode shows up at the first busy interval or completion event after the bad write. The pin then drives during busy in a pulse mode, or pulses on a completion that should be masked, one cycle after the stimulus. A faulty pulse counter shows as a pulse one cycle too long or too short, or as a gap during a restart, within `PULSE_LEN` + 1 cycles of the event. A lost power-down clear shows the next cycle as an enable that stays high, and later as a pulse mode that survives power-down.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic [1:0] {
        MODE_LEVEL = 2'b00,
        MODE_ERASE = 2'b01,
        MODE_PROG  = 2'b10,
        MODE_ANY   = 2'b11
    } sts_mode_e;

    typedef struct packed {
        logic erase_done;
        logic prog_done;
    } wsm_done_t;

    typedef struct packed {
        logic busy;
        logic erase_susp;
        logic prog_susp;
    } wsm_state_t;

    function automatic logic is_pulse_mode(sts_mode_e m);
        return m != MODE_LEVEL;
    endfunction

    function automatic logic done_hits(sts_mode_e m, wsm_done_t d);
        logic hit;
        unique case (m)
            MODE_ERASE: hit = d.erase_done;
            MODE_PROG:  hit = d.prog_done;
            MODE_ANY:   hit = d.erase_done | d.prog_done;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic level_wants_drive(wsm_state_t s);
        return s.busy & ~s.erase_susp & ~s.prog_susp;
    endfunction

endpackage

// File: rtl/sts_cfg_reg.sv
module sts_cfg_reg
    import sts_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pdn_n,
    input  logic      wsm_busy,
    input  logic      cfg_wr,
    input  logic [1:0] cfg_code,
    output sts_mode_e mode,
    output logic      cfg_accept
);

    sts_mode_e mode_q;

    assign cfg_accept = cfg_wr & ~wsm_busy & pdn_n;

    always_ff @(posedge clk) begin
        if (rst || !pdn_n) begin
            mode_q <= MODE_LEVEL;
        end else if (cfg_accept) begin
            mode_q <= sts_mode_e'(cfg_code);
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/sts_level_trk.sv
module sts_level_trk
    import sts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pdn_n,
    input  wsm_state_t wsm,
    output logic       level_drive
);

    logic drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= pdn_n & level_wants_drive(wsm);
        end
    end

    assign level_drive = drive_q;

endmodule

// File: rtl/sts_pulse_gen.sv
module sts_pulse_gen #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic trigger,
    output logic active
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (trigger) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/sts_pin_ctrl.sv
module sts_pin_ctrl
    import sts_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pdn_n,
    input  logic       wsm_busy,
    input  logic       erase_done,
    input  logic       prog_done,
    input  logic       erase_susp,
    input  logic       prog_susp,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_code,
    output logic       sts_out,
    output logic       sts_oe
);

    sts_mode_e  mode_q;
    logic       cfg_accept;
    logic       level_drive;
    logic       pulse_active;
    logic       pulse_trig;
    logic       pulse_clear;
    wsm_done_t  done_ev;
    wsm_state_t wsm_st;

    assign done_ev = '{erase_done: erase_done, prog_done: prog_done};
    assign wsm_st  = '{busy: wsm_busy, erase_susp: erase_susp, prog_susp: prog_susp};

    sts_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .pdn_n      (pdn_n),
        .wsm_busy   (wsm_busy),
        .cfg_wr     (cfg_wr),
        .cfg_code   (cfg_code),
        .mode       (mode_q),
        .cfg_accept (cfg_accept)
    );

    sts_level_trk u_level (
        .clk         (clk),
        .rst         (rst),
        .pdn_n       (pdn_n),
        .wsm         (wsm_st),
        .level_drive (level_drive)
    );

    assign pulse_clear = cfg_accept | ~pdn_n;
    assign pulse_trig  = is_pulse_mode(mode_q) & done_hits(mode_q, done_ev);

    sts_pulse_gen #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .clear   (pulse_clear),
        .trigger (pulse_trig),
        .active  (pulse_active)
    );

    always_comb begin
        if (is_pulse_mode(mode_q)) begin
            sts_oe = pulse_active;
        end else begin
            sts_oe = level_drive;
        end
        sts_out = ~sts_oe;
    end

endmodule

// File: rtl/sts_pin_chk.sv
module sts_pin_chk
    import sts_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      pdn_n,
    input logic      wsm_busy,
    input logic      erase_done,
    input logic      prog_done,
    input logic      erase_susp,
    input logic      prog_susp,
    input logic      cfg_wr,
    input sts_mode_e mode,
    input logic      sts_out,
    input logic      sts_oe
);

    // R2
    a_r2_level_busy_drives: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LEVEL && wsm_busy && !erase_susp && !prog_susp && pdn_n) |=> sts_oe);

    // R3
    a_r3_level_idle_release: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LEVEL && (!wsm_busy || erase_susp || prog_susp)) |=> !sts_oe);

    // R4
    a_r4_pulse_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_LEVEL && !sts_oe && !erase_done && !prog_done) |=> !sts_oe);

    // R5
    a_r5_erase_pulse_start: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_ERASE || mode == MODE_ANY) && erase_done && pdn_n
         && !(cfg_wr && !wsm_busy)) |=> sts_oe);

    // R5
    a_r5_prog_pulse_start: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_PROG || mode == MODE_ANY) && prog_done && pdn_n
         && !(cfg_wr && !wsm_busy)) |=> sts_oe);

    // R7
    a_r7_cfg_blocked_busy: assert property (@(posedge clk) disable iff (rst)
        (wsm_busy && pdn_n) |=> $stable(mode));

    // R8
    a_r8_pdn_release: assert property (@(posedge clk) disable iff (rst)
        !pdn_n |=> (!sts_oe && mode == MODE_LEVEL));

    // R9
    a_r9_out_complement: assert property (@(posedge clk) disable iff (rst)
        sts_out == !sts_oe);

endmodule

bind sts_pin_ctrl sts_pin_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pdn_n      (pdn_n),
    .wsm_busy   (wsm_busy),
    .erase_done (erase_done),
    .prog_done  (prog_done),
    .erase_susp (erase_susp),
    .prog_susp  (prog_susp),
    .cfg_wr     (cfg_wr),
    .mode       (mode_q),
    .sts_out    (sts_out),
    .sts_oe     (sts_oe)
);

// File: tb/tb_sts_pin_ctrl.sv
module tb_sts_pin_ctrl;

    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pdn_n = 1'b1;
    logic       wsm_busy = 1'b0;
    logic       erase_done = 1'b0;
    logic       prog_done = 1'b0;
    logic       erase_susp = 1'b0;
    logic       prog_susp = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_code = 2'b00;
    logic       sts_out;
    logic       sts_oe;

    always #2 clk = ~clk;

    sts_pin_ctrl #(.PULSE_LEN(PL)) dut (
        .clk        (clk),
        .rst        (rst),
        .pdn_n      (pdn_n),
        .wsm_busy   (wsm_busy),
        .erase_done (erase_done),
        .prog_done  (prog_done),
        .erase_susp (erase_susp),
        .prog_susp  (prog_susp),
        .cfg_wr     (cfg_wr),
        .cfg_code   (cfg_code),
        .sts_out    (sts_out),
        .sts_oe     (sts_oe)
    );

    typedef struct {
        int    stamp;
        bit    oe;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops items due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp == cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (sts_oe !== e.oe) begin
                bad++;
                $display("FAIL %s: sts_oe=%b expected %b", e.tag, sts_oe, e.oe);
            end
            total++;
            if (sts_out !== ~e.oe) begin
                bad++;
                $display("FAIL R9 (%s): sts_out=%b expected %b", e.tag, sts_out, ~e.oe);
            end
        end
    end

    task automatic drv(bit b, bit ed, bit pd, bit es, bit ps, bit pn,
                       bit wr, logic [1:0] code, bit exp_oe, string tag);
        exp_t e;
        @(negedge clk);
        wsm_busy   = b;
        erase_done = ed;
        prog_done  = pd;
        erase_susp = es;
        prog_susp  = ps;
        pdn_n      = pn;
        cfg_wr     = wr;
        cfg_code   = code;
        e.stamp = cyc + 1;
        e.oe    = exp_oe;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic idle(bit exp_oe, string tag);
        drv(0, 0, 0, 0, 0, 1, 0, 2'b00, exp_oe, tag);
    endtask

    task automatic busy(bit exp_oe, string tag);
        drv(1, 0, 0, 0, 0, 1, 0, 2'b00, exp_oe, tag);
    endtask

    task automatic cfg(logic [1:0] code, string tag);
        drv(0, 0, 0, 0, 0, 1, 1, code, 1'b0, tag);
    endtask

    task automatic fin();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            fin();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(0, "R1 reset state");
        idle(0, "R1 reset state");

        busy(1, "R2 level busy");
        busy(1, "R2 level busy held");
        drv(1, 0, 0, 1, 0, 1, 0, 2'b00, 0, "R3 erase suspended");
        drv(1, 0, 0, 0, 1, 1, 0, 2'b00, 0, "R3 program suspended");
        busy(1, "R2 level busy again");
        idle(0, "R3 level ready");
        drv(0, 1, 0, 0, 0, 1, 0, 2'b00, 0, "R3 erase done ignored");
        drv(0, 0, 1, 0, 0, 1, 0, 2'b00, 0, "R3 prog done ignored");

        drv(1, 0, 0, 0, 0, 1, 1, 2'b01, 1, "R7 cfg while busy");
        drv(0, 1, 0, 0, 0, 1, 0, 2'b00, 0, "R7 mode kept level");

        drv(1, 0, 0, 0, 0, 0, 0, 2'b00, 0, "R8 power-down releases");
        busy(1, "R2 after power-down");
        idle(0, "R3 idle");

        cfg(2'b01, "R7 accept code 01");
        busy(0, "R4 busy no drive");
        drv(0, 1, 0, 0, 0, 1, 0, 2'b00, 1, "R5 erase pulse c1");
        idle(1, "R5 erase pulse c2");
        idle(1, "R5 erase pulse c3");
        idle(1, "R5 erase pulse c4");
        idle(0, "R5 erase pulse end");
        drv(0, 0, 1, 0, 0, 1, 0, 2'b00, 0, "R5 prog masked in 01");
        idle(0, "R4 quiet");

        cfg(2'b10, "R7 accept code 10");
        drv(0, 0, 1, 0, 0, 1, 0, 2'b00, 1, "R5 prog pulse c1");
        idle(1, "R5 prog pulse c2");
        idle(1, "R5 prog pulse c3");
        idle(1, "R5 prog pulse c4");
        idle(0, "R5 prog pulse end");
        drv(0, 1, 0, 0, 0, 1, 0, 2'b00, 0, "R5 erase masked in 10");

        cfg(2'b11, "R7 accept code 11");
        drv(0, 1, 0, 0, 0, 1, 0, 2'b00, 1, "R5 any erase c1");
        idle(1, "R6 before retrigger");
        drv(0, 0, 1, 0, 0, 1, 0, 2'b00, 1, "R6 retrigger");
        idle(1, "R6 restarted c2");
        idle(1, "R6 restarted c3");
        idle(1, "R6 restarted c4");
        idle(0, "R6 single end");

        drv(0, 1, 0, 0, 0, 1, 0, 2'b00, 1, "R5 pulse before cfg");
        cfg(2'b11, "R7 accepted write clears pulse");
        idle(0, "R7 stays clear");

        drv(0, 0, 1, 0, 0, 1, 0, 2'b00, 1, "R5 pulse before pdn");
        drv(0, 0, 0, 0, 0, 0, 0, 2'b00, 0, "R8 pulse cancelled");
        idle(0, "R8 released");
        busy(1, "R8 mode back to level");
        idle(0, "R3 final idle");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        fin();
    end

endmodule